// File: doc/BRIEF.md
# Multi-register stack transfer sequencer

This controller carries out the multi-word transfers of a compact 16-bit instruction set: push, pop, load-multiple and store-multiple. It works over an 8-bit list of low registers, plus one extra register chosen by a flag. For a push the extra register is the link register. For a pop it is the program counter. A start pulse hands the sequencer four things: the operation, the list, the flag and the base (or stack-pointer) value. From then on it issues one 32-bit word access per accepted bus cycle over a valid/ready handshake.

For a store, the sequencer names the register it needs on a read index. The register file answers on the same cycle. For a load, every word that arrives goes back out as a register write-back. When the whole list is done, the block pulses `done` for one cycle and presents the final base value, which the caller writes back. When the program counter is loaded, the block also raises a one-cycle pipeline-flush request.

The sequencer walks only the set bits of the list. A transfer of n words therefore uses exactly n accepted bus cycles.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset, `mem_valid`, `wb_valid`, `flush` and `done` are all low.
- R2: Push is op code 0. When `extra` is set, register 14 is stored first at base-4. The listed registers follow, from the highest to the lowest number, and each one goes 4 below the previous address. With n words, `base_out` equals base-4n when `done` is high.
- R3: Pop is op code 1. The listed registers are read from the lowest to the highest number at base, base+4, and so on. When `extra` is set, register 15 is read last. Each read is written back, and `base_out` equals base+4n when `done` is high.
- R4: A word popped into register 15 is written back with bit 0 cleared. `flush` is high in exactly that write-back cycle and in no other.
- R5: Load-multiple (op code 2) and store-multiple (op code 3) walk ascending addresses from base, in steps of 4 and in register-number order. `extra` has no effect on them, and `base_out` equals base+4n when `done` is high.
- R6: List bit i stands for register i. Clear bits take no bus cycle. With `mem_ready` held high, exactly n accesses occur and `done` comes n+1 cycles after the start cycle.
- R7: An empty list with no extra register makes no bus access. `done` comes one cycle after start, with `base_out` equal to base.
- R8: While `mem_valid` is high and `mem_ready` is low, the request is held unchanged into the next cycle.
- R9: A start pulse that arrives during a transfer is ignored.
- R10: A bus request only ever follows an accepted start. `done` is never high while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 push, 1 pop, 2 load-multiple, 3 store-multiple |
| reg_list | input | 8 | Low-register list, bit i is register i |
| extra | input | 1 | Also transfer the link register (push) or the program counter (pop) |
| base_in | input | 32 | Base or stack-pointer value |
| rf_idx | output | 4 | Register whose value is to be stored |
| rf_data | input | 32 | Value of register `rf_idx`, same cycle |
| mem_valid | output | 1 | Bus request |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Bus accepts the request (read data valid) |
| mem_rdata | input | 32 | Read data |
| wb_valid | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Register written back |
| wb_data | output | 32 | Write-back value |
| flush | output | 1 | Pipeline-flush request on a program-counter load |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Final base value, valid with `done` |

## Verification
The cases that are hardest to reach from the ports are those where the list order interacts with bus stalls and with a stray start pulse in the middle of a transfer. A mis-sequenced pending mask only shows up there, as a skipped, repeated or reordered word. The bench sweeps all 256 lists under every operation, with the extra flag both set and clear. It stalls `mem_ready` in a rotating pattern on part of the sweep. On another part it drives a conflicting start on the first busy cycle. It then compares every accepted access and write-back against an order computed from the list bits.

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter int W      = 32,
  parameter int LW     = 8,
  parameter int IW     = 4,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [LW-1:0] reg_list,
  input  logic          extra,
  input  logic [W-1:0]  base_in,
  output logic [IW-1:0] rf_idx,
  input  logic [W-1:0]  rf_data,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ready,
  input  logic [W-1:0]  mem_rdata,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [W-1:0]  wb_data,
  output logic          flush,
  output logic          done,
  output logic [W-1:0]  base_out
);
  localparam int SW = $clog2(LW + 1);
  localparam logic [W-1:0] STEP = W'(4);
  localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_LDM = 2'd2;

  logic          busy_q, done_q;
  logic [LW:0]   pend_q;
  logic [W-1:0]  addr_q;
  logic [1:0]    op_q;
  logic [SW-1:0] sel;
  logic [LW:0]   sel_mask;
  logic [IW-1:0] cur_idx;

  wire is_push = (op_q == OP_PUSH);
  wire is_load = (op_q == OP_POP) || (op_q == OP_LDM);
  wire hs      = busy_q && mem_ready;
  wire [LW:0] start_mask = {extra && (op == OP_PUSH || op == OP_POP), reg_list};
  wire last    = ((pend_q & ~sel_mask) == '0);

  always_comb begin
    sel = SW'(LW);
    if (is_push) begin
      if (!pend_q[LW])
        for (int i = 0; i < LW; i++)
          if (pend_q[i]) sel = SW'(i);
    end else begin
      for (int i = LW - 1; i >= 0; i--)
        if (pend_q[i]) sel = SW'(i);
    end
  end

  assign sel_mask = (LW+1)'(1) << sel;
  assign cur_idx  = (sel == SW'(LW)) ? (is_push ? IW'(LR_IDX) : IW'(PC_IDX)) : IW'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      addr_q <= '0;
      op_q   <= OP_PUSH;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        op_q   <= op;
        addr_q <= base_in;
        pend_q <= start_mask;
        if (start_mask == '0) done_q <= 1'b1;
        else                  busy_q <= 1'b1;
      end else if (hs) begin
        pend_q <= pend_q & ~sel_mask;
        addr_q <= is_push ? addr_q - STEP : addr_q + STEP;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rf_idx    = cur_idx;
  assign mem_valid = busy_q;
  assign mem_write = !is_load;
  assign mem_addr  = is_push ? addr_q - STEP : addr_q;
  assign mem_wdata = rf_data;
  assign wb_valid  = hs && is_load;
  assign wb_idx    = cur_idx;
  assign wb_data   = (cur_idx == IW'(PC_IDX)) ? (mem_rdata & ~W'(1)) : mem_rdata;
  assign flush     = wb_valid && (cur_idx == IW'(PC_IDX));
  assign done      = done_q;
  assign base_out  = addr_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R4
  flush_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (wb_valid && !wb_data[0] && wb_idx == IW'(PC_IDX)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(start));

  // R2
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write && is_push && !last) |=>
      (mem_addr == $past(mem_addr) - STEP));
endmodule

// File: tb/test_stack_xfer_seq.sv
module test_stack_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  reg_list = 8'd0;
  logic        extra = 1'b0;
  logic [31:0] base_in = 32'd0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mem_valid, mem_write, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        wb_valid, flush, done;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data, base_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rfval(input logic [3:0] i);
    return {16'hC0DE, 12'h000, i};
  endfunction
  function automatic logic [31:0] memval(input logic [31:0] a);
    return a ^ 32'h1357_9BDF;
  endfunction

  assign rf_data   = rfval(rf_idx);
  assign mem_rdata = memval(mem_addr);

  stack_xfer_seq i_stack_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_list(reg_list),
    .extra(extra), .base_in(base_in), .rf_idx(rf_idx), .rf_data(rf_data),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .flush(flush),
    .done(done), .base_out(base_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [7:0] lst, input logic ext);
    logic [3:0]  eidx[10];
    logic [31:0] base;
    logic [31:0] ea, ed;
    int n = 0, hk = 0, dc = 0, nfl = 0;
    bit stall, inj, seq_ok = 1'b1;
    string req;
    base = 32'h0000_4000 + {lst, 4'h0};
    req = (lst == 0 && !(ext && o < 2)) ? "R7" : (o == 0) ? "R2" : (o == 1) ? "R3" : "R5";
    if (o == 2'd0) begin
      if (ext) begin eidx[n] = 4'd14; n++; end
      for (int i = 7; i >= 0; i--) if (lst[i]) begin eidx[n] = 4'(i); n++; end
    end else begin
      for (int i = 0; i < 8; i++) if (lst[i]) begin eidx[n] = 4'(i); n++; end
      if (ext && o == 2'd1) begin eidx[n] = 4'd15; n++; end
    end
    stall = lst[2] ^ ext;
    inj = lst[1] && (n >= 2);

    @(negedge clk);
    start = 1'b1; op = o; reg_list = lst; extra = ext; base_in = base; mem_ready = 1'b1;
    for (int cyc = 1; cyc <= 60; cyc++) begin
      @(negedge clk);
      if (cyc == 1 && inj) begin
        start = 1'b1; op = ~o; reg_list = ~lst; extra = ~ext; base_in = 32'h0000_9000;
      end else start = 1'b0;
      mem_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (flush) nfl++;
      if (mem_valid && mem_ready) begin
        if (hk >= n) begin
          if (seq_ok) $display("FAIL %s extra access: actual=%h expected=none", req, mem_addr);
          seq_ok = 1'b0;
        end else begin
          ea = (o == 2'd0) ? base - 32'(4 * (hk + 1)) : base + 32'(4 * hk);
          ed = memval(ea);
          if (eidx[hk] == 4'd15) ed[0] = 1'b0;
          if (mem_addr != ea || mem_write != (o == 2'd0 || o == 2'd3)) begin
            if (seq_ok) $display("FAIL %s access %0d addr: actual=%h expected=%h", req, hk, mem_addr, ea);
            seq_ok = 1'b0;
          end else if (mem_write && (mem_wdata != rfval(eidx[hk]) || wb_valid)) begin
            if (seq_ok) $display("FAIL %s store %0d data: actual=%h expected=%h", req, hk, mem_wdata, rfval(eidx[hk]));
            seq_ok = 1'b0;
          end else if (!mem_write && (!wb_valid || wb_idx != eidx[hk] || wb_data != ed)) begin
            if (seq_ok) $display("FAIL %s load %0d writeback: actual=%h expected=%h", req, hk, wb_data, ed);
            seq_ok = 1'b0;
          end
        end
        hk++;
      end
      if (done) begin dc = cyc; break; end
    end
    start = 1'b0;
    total++;
    if (!seq_ok) bad++;
    chk(dc != 0, req, "done seen", 32'(dc), 32'd1);
    chk(hk == n, "R6", "access count", 32'(hk), 32'(n));
    chk(base_out == ((o == 2'd0) ? base - 32'(4 * n) : base + 32'(4 * n)), req, "final base",
        base_out, (o == 2'd0) ? base - 32'(4 * n) : base + 32'(4 * n));
    chk(nfl == ((o == 2'd1 && ext) ? 1 : 0), "R4", "flush count", 32'(nfl), 32'((o == 2'd1 && ext) ? 1 : 0));
    if (!stall) chk(dc == n + 1, (n == 0) ? "R7" : "R6", "done latency", 32'(dc), 32'(n + 1));
    if (inj) chk(seq_ok && hk == n, "R9", "start during transfer ignored", 32'(hk), 32'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_valid && !wb_valid && !flush && !done, "R1", "reset outputs",
        {28'h0, mem_valid, wb_valid, flush, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_valid && !done, "R1", "idle after reset", {30'h0, mem_valid, done}, 32'h0);
    for (int o = 0; o < 4; o++)
      for (int e = 0; e < 2; e++)
        for (int l = 0; l < 256; l++)
          run(2'(o), 8'(l), e[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule